// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block produces the address stream for a processor-style burst of four transfers. A burst begins when either of two active-low start strobes is sampled low on a rising clock edge. At that edge the block captures the externally presented address. On each later edge it either steps to the next beat or waits on the current one. The step happens when the active-low advance input is low. The wait happens when that input is high.

The output address keeps the captured upper bits unchanged. Only the two lowest bits are replaced by a burst offset. A mode input picks the order of that offset:

- **Linear order:** the offset is the start offset plus the beat count, wrapping modulo four.
- **Interleaved order:** the offset is the start offset XOR the beat count.

The block sits between the address pins and the array decoder of a synchronous burst memory. Memory access, chip selection and write control belong to other blocks.

The burst length, the address width and the set of supported orders are parameters. The defaults are a four-beat burst, an 18-bit address and both orders selectable at run time.

Top module: `burst_addr_seq`

## Requirements
- R1: A synchronous reset, active high on `rst`, clears both the captured address and the beat count, so `addr_out` reads all zeros on the cycle after reset.
- R2: When `strobe_a_n` or `strobe_b_n` (or both) is low at a rising edge, the block captures `addr_in` and zeroes the beat count. From the next cycle `addr_out` equals the captured address exactly.
- R3: With `ilv_sel` = 0 (linear), the low two bits of `addr_out` equal (start offset + beat count) mod 4. Starting at 01, for example, the order is 01, 10, 11, 00.
- R4: With `ilv_sel` = 1 (interleaved), the low two bits of `addr_out` equal start offset XOR beat count. Starting at 01, for example, the order is 01, 00, 11, 10.
- R5: With both strobes high and `adv_n` low at a rising edge, the beat count increases by one.
- R6: With both strobes high and `adv_n` high at a rising edge, the beat count and `addr_out` are unchanged (wait cycle).
- R7: Advancing past the fourth beat wraps the beat count to zero, so the fifth address equals the first.
- R8: Bits `addr_out[17:2]` change only when a strobe loads a new address or reset clears them; advancing never alters them.
- R9: A strobe takes priority over `adv_n`. A start in the same edge as an advance loads the new address at beat zero.
- R10: `ilv_sel` acts on the output directly with no clock edge. Changing it mid-burst re-maps the current beat at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| strobe_a_n | input | 1 | First burst-start strobe, active low |
| strobe_b_n | input | 1 | Second burst-start strobe, active low |
| adv_n | input | 1 | Advance to next beat when low, wait when high |
| ilv_sel | input | 1 | Burst order: 0 linear, 1 interleaved |
| addr_in | input | 18 | Address captured at burst start |
| addr_out | output | 18 | Current burst address |

## Verification
The bench walks all four start offsets in both orders through a full burst and one extra advance. A design that adds where it should XOR, or the reverse, shows a wrong offset on the second or fourth beat. A counter that saturates instead of wrapping repeats the last offset on the fifth beat. Directed cases cover the following:

- Wait cycles: a design that advanced anyway would drift the address.
- A strobe coinciding with an advance: a wrong priority would leave the new burst at beat one.
- A mode flip with no clock edge: a registered mode would lag by a cycle.
- Reset mid-burst: a design that cleared only the counter would leave the old upper bits visible.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

   // Which burst orders an instance supports.
   typedef enum logic [1:0] {
      ORDER_BOTH        = 2'd0,  // run-time choice through ilv_sel
      ORDER_LINEAR_ONLY = 2'd1,
      ORDER_ILV_ONLY    = 2'd2
   } order_set_e;

   // True when n is a power of two no smaller than 2.
   function automatic bit is_pow2(input int n);
      return (n >= 2) && ((n & (n - 1)) == 0);
   endfunction

endpackage

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
   parameter int CNT_W = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic             step,
   output logic [CNT_W-1:0] cnt
);

   if (CNT_W < 1) begin : g_bad_w
      $error("burst_beat_ctr: CNT_W must be at least 1");
   end

   logic [CNT_W-1:0] cnt_q;

   // Load has priority over step; the counter wraps naturally.
   always_ff @(posedge clk) begin
      if (rst)       cnt_q <= '0;
      else if (load) cnt_q <= '0;
      else if (step) cnt_q <= cnt_q + 1'b1;
   end

   assign cnt = cnt_q;

   p_load_zero_r9 : assert property (@(posedge clk) disable iff (rst)
      load |=> (cnt == '0));

   // Also covers R7: the cast wraps the expected value at the last beat.
   p_adv_step_r5 : assert property (@(posedge clk) disable iff (rst)
      (!load && step) |=> (cnt == CNT_W'($past(cnt) + 1)));

   p_wait_hold_r6 : assert property (@(posedge clk) disable iff (rst)
      (!load && !step) |=> $stable(cnt));

endmodule

// File: rtl/burst_addr_latch.sv
module burst_addr_latch #(
   parameter int ADDR_W = 18
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic [ADDR_W-1:0] d,
   output logic [ADDR_W-1:0] q
);

   if (ADDR_W < 2) begin : g_bad_w
      $error("burst_addr_latch: ADDR_W must be at least 2");
   end

   logic [ADDR_W-1:0] q_r;

   always_ff @(posedge clk) begin
      if (rst)       q_r <= '0;
      else if (load) q_r <= d;
   end

   assign q = q_r;

   p_keep_r8 : assert property (@(posedge clk) disable iff (rst)
      !load |=> $stable(q));

endmodule

// File: rtl/burst_offset_map.sv
module burst_offset_map
   import burst_seq_pkg::*;
#(
   parameter int         OFF_W  = 2,
   parameter order_set_e ORDERS = ORDER_BOTH
) (
   input  logic [OFF_W-1:0] start_off,
   input  logic [OFF_W-1:0] beat,
   input  logic             ilv_sel,
   output logic [OFF_W-1:0] off
);

   logic [OFF_W-1:0] lin_off;
   logic [OFF_W-1:0] ilv_off;

   assign lin_off = start_off + beat;   // modulo 2**OFF_W
   assign ilv_off = start_off ^ beat;

   if (ORDERS == ORDER_BOTH) begin : g_both
      assign off = ilv_sel ? ilv_off : lin_off;
   end else if (ORDERS == ORDER_LINEAR_ONLY) begin : g_lin
      assign off = lin_off;
   end else begin : g_ilv
      assign off = ilv_off;
   end

   // Beat zero lands on the start offset under every order.
   always_comb begin
      if (beat == '0) begin
         a_beat0_start_r2 : assert (off == start_off);
      end
   end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
   import burst_seq_pkg::*;
#(
   parameter int         ADDR_W    = 18,
   parameter int         BURST_LEN = 4,
   parameter order_set_e ORDERS    = ORDER_BOTH
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              strobe_a_n,
   input  logic              strobe_b_n,
   input  logic              adv_n,
   input  logic              ilv_sel,
   input  logic [ADDR_W-1:0] addr_in,
   output logic [ADDR_W-1:0] addr_out
);

   localparam int OFF_W = $clog2(BURST_LEN);

   if (!is_pow2(BURST_LEN)) begin : g_bad_len
      $error("burst_addr_seq: BURST_LEN must be a power of two >= 2");
   end
   if (ADDR_W <= OFF_W) begin : g_bad_aw
      $error("burst_addr_seq: ADDR_W must exceed the offset width");
   end

   logic              start;
   logic              step;
   logic [ADDR_W-1:0] base_q;
   logic [OFF_W-1:0]  beat_q;
   logic [OFF_W-1:0]  off;

   assign start = !strobe_a_n || !strobe_b_n;
   assign step  = !adv_n;

   burst_addr_latch #(.ADDR_W(ADDR_W)) u_latch (
      .clk  (clk),
      .rst  (rst),
      .load (start),
      .d    (addr_in),
      .q    (base_q)
   );

   burst_beat_ctr #(.CNT_W(OFF_W)) u_ctr (
      .clk  (clk),
      .rst  (rst),
      .load (start),
      .step (step),
      .cnt  (beat_q)
   );

   burst_offset_map #(.OFF_W(OFF_W), .ORDERS(ORDERS)) u_map (
      .start_off (base_q[OFF_W-1:0]),
      .beat      (beat_q),
      .ilv_sel   (ilv_sel),
      .off       (off)
   );

   assign addr_out = {base_q[ADDR_W-1:OFF_W], off};

   p_load_addr_r2 : assert property (@(posedge clk) disable iff (rst)
      start |=> (addr_out == $past(addr_in)));

   p_upper_keep_r8 : assert property (@(posedge clk) disable iff (rst)
      !start |=> $stable(addr_out[ADDR_W-1:OFF_W]));

   p_reset_clear_r1 : assert property (@(posedge clk)
      rst |=> (addr_out[ADDR_W-1:OFF_W] == '0));

endmodule

// File: tb/burst_addr_seq_tb_top.sv
module burst_addr_seq_tb_top;

   localparam int AW = 18;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          strobe_a_n = 1'b1;
   logic          strobe_b_n = 1'b1;
   logic          adv_n = 1'b1;
   logic          ilv_sel = 1'b0;
   logic [AW-1:0] addr_in = '0;
   logic [AW-1:0] addr_out;

   int n_checks = 0;
   int n_fail   = 0;

   always #2 clk = ~clk;   // 4 ns period

   burst_addr_seq dut_i (
      .clk        (clk),
      .rst        (rst),
      .strobe_a_n (strobe_a_n),
      .strobe_b_n (strobe_b_n),
      .adv_n      (adv_n),
      .ilv_sel    (ilv_sel),
      .addr_in    (addr_in),
      .addr_out   (addr_out)
   );

   // Vector layout: {ilv_sel, start[1:0], beat0, beat1, beat2, beat3}.
   localparam logic [10:0] VEC [8] = '{
      {1'b0, 2'b00, 8'b00_01_10_11},
      {1'b0, 2'b01, 8'b01_10_11_00},
      {1'b0, 2'b10, 8'b10_11_00_01},
      {1'b0, 2'b11, 8'b11_00_01_10},
      {1'b1, 2'b00, 8'b00_01_10_11},
      {1'b1, 2'b01, 8'b01_00_11_10},
      {1'b1, 2'b10, 8'b10_11_00_01},
      {1'b1, 2'b11, 8'b11_10_01_00}
   };

   task automatic check(input string req, input logic [AW-1:0] got,
                        input logic [AW-1:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   endtask

   // Watchdog: a hung run counts as one failed check.
   initial begin
      repeat (20000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      logic [AW-1:0] a;
      logic [AW-1:0] b;

      // R1: reset state.
      repeat (2) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      check("R1 reset", addr_out, '0);

      // Table walk: both orders, all starts, full burst plus wrap.
      for (int i = 0; i < 8; i++) begin
         a = {16'h1230 + 16'(i * 16'h0111), VEC[i][9:8]};
         ilv_sel    = VEC[i][10];
         addr_in    = a;
         strobe_a_n = (i % 2 == 0) ? 1'b0 : 1'b1;
         strobe_b_n = (i % 2 == 0) ? 1'b1 : 1'b0;
         adv_n      = 1'b1;
         @(negedge clk);
         strobe_a_n = 1'b1;
         strobe_b_n = 1'b1;
         check("R2 load", addr_out, a);
         adv_n = 1'b0;
         for (int bt = 1; bt < 4; bt++) begin
            @(negedge clk);
            check(VEC[i][10] ? "R4 interleaved" : "R3 linear",
                  {a[AW-1:2], VEC[i][7 - 2*bt -: 2]}, addr_out);
            check("R8 upper", {addr_out[AW-1:2], 2'b00}, {a[AW-1:2], 2'b00});
         end
         @(negedge clk);
         check("R7 wrap", addr_out, a);
         adv_n = 1'b1;
      end

      // R6: wait cycles hold, then R5 single step (linear from 10).
      ilv_sel = 1'b0;
      a = 18'h2AB56;  // low bits 10
      addr_in = a;
      strobe_a_n = 1'b0;
      @(negedge clk);
      strobe_a_n = 1'b1;
      adv_n = 1'b0;
      @(negedge clk);
      adv_n = 1'b1;
      check("R5 step", addr_out, {a[AW-1:2], 2'b11});
      repeat (3) @(negedge clk);
      check("R6 wait", addr_out, {a[AW-1:2], 2'b11});

      // R10: mode flip with no edge re-maps the current beat (start 10, beat 1).
      ilv_sel = 1'b1;
      #1;
      check("R10 mode live", addr_out, {a[AW-1:2], 2'b11});
      addr_in = 18'h0F0F1;  // start 01
      strobe_b_n = 1'b0;
      @(negedge clk);
      strobe_b_n = 1'b1;
      adv_n = 1'b0;
      @(negedge clk);
      adv_n = 1'b1;
      check("R4 beat1 from 01", addr_out, 18'h0F0F0);
      ilv_sel = 1'b0;
      #1;
      check("R10 mode live", addr_out, 18'h0F0F2);

      // R9: strobe together with advance loads at beat zero.
      b = 18'h3C003;
      addr_in = b;
      strobe_a_n = 1'b0;
      adv_n = 1'b0;
      @(negedge clk);
      strobe_a_n = 1'b1;
      check("R9 strobe priority", addr_out, b);
      @(negedge clk);
      adv_n = 1'b1;
      check("R3 after priority", addr_out, 18'h3C000);

      // R1: reset mid-burst clears everything.
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      check("R1 mid-burst reset", addr_out, '0);
      adv_n = 1'b0;
      @(negedge clk);
      adv_n = 1'b1;
      check("R5 step after reset", addr_out, 18'h00001);

      finish_run();
   end

endmodule